// File: doc/BRIEF.md
# Transmit Descriptor-Chain DMA Channel

This block is one transmit DMA channel. Software builds a linked list of four-word buffer descriptors in memory and writes the address of the first one to the head pointer register. The engine then walks the list. For each descriptor it reads the link, buffer-address and mode words and streams the buffer as one packet of bytes, with start and end flags. It then writes the mode word back with the ownership flag released. When the link word is zero, the engine also sets the end-of-queue flag and stops. Software can therefore append to a chain that is still running. If it appended too late, it sees end-of-queue set and restarts the channel from the new descriptor.

Software reaches the block through a small word-indexed register bus. The registers are head pointer (index 0), completion pointer (1), enable (2), command (3), status (4) and soft reset (5). Read data is registered and returns the cycle after the index is presented. Descriptors and buffers are reached through a single-beat 32-bit memory master with one access in flight at a time.

Top module: `tdma_tx_chan`

## Requirements
- R1: After reset, status (index 4) reads 0x8000_0000 (bit 31 idle = 1, bit 0 fault = 0). Head and completion read 0. The memory request and the stream valid are low.
- R2: A descriptor at address D is read as the link word at D+0, then the buffer address at D+4, then the mode word at D+12. The buffer-length word at D+8 is never read.
- R3: The packet length is mode bits 10:0. That many bytes are sent from the word-aligned buffer, little-endian within each word. The start flag is on the first byte and the end flag on the last. A byte stays unchanged while the stream ready input is low.
- R4: After the last byte, the engine writes the mode word to D+12 with bit 29 (owner) cleared. It sets bit 28 (end-of-queue) exactly when the link word is zero. All other bits are unchanged.
- R5: A non-zero link word leads straight to that descriptor. While a descriptor is in flight, head reads its address. After a chain ends, head reads 0.
- R6: A mode length of 0 sends no bytes and still performs the write-back.
- R7: If the mode word has bit 29 clear when fetched, the engine sends nothing and writes nothing. Status bit 0 is set, head keeps its value, and no later descriptor starts until a soft reset.
- R8: While enable (index 2, bit 0) is 0, no descriptor starts and no memory access is made. A head written meanwhile is kept and starts once enable is set to 1.
- R9: While command bit 3 (index 3) is 1, no new descriptor starts. Status bit 31 reads 1 whenever the engine is not working on a descriptor.
- R10: A head write is accepted only when the engine is idle and head reads 0. Otherwise it is ignored.
- R11: The completion register stores the value written and reads it back.
- R12: Writing 1 to bit 0 of the soft-reset register (index 5) reinitialises the channel on the next cycle, and the bit then reads 0 again. Head, completion, the fault flag and the idle command are cleared. Enable keeps its value.
- R13: The memory master has at most one access open. A request keeps its address, direction and write data until ready is seen.
- R14: A link word changed in memory after the engine has read it is not followed. That descriptor is written back with end-of-queue set, and a later head write to the appended descriptor sends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RIW | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data, one cycle after the index |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| tx_valid | output | 1 | Byte on tx_data is valid |
| tx_ready | input | 1 | Sink takes the byte |
| tx_data | output | 8 | Packet byte |
| tx_sop | output | 1 | First byte of a packet |
| tx_eop | output | 1 | Last byte of a packet |

## Verification
Stream bytes and write-backs happen at handshakes whose timing depends on memory latency and sink stalls. The reference model therefore keeps queues of expected bytes and expected write-backs, and compares each handshake on the clock where it occurs. A head write becomes visible to the engine one cycle after the write cycle, and the first memory request follows one cycle later. Register read data is checked one cycle after the index is presented. Soft-reset effects are read no earlier than two cycles after the write, and absence of activity (disabled, idle command, fault) is checked as an unchanged count of requested memory cycles over a fixed window.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LEN_W    = 11;
  localparam int unsigned B_SOP    = 31;
  localparam int unsigned B_EOP    = 30;
  localparam int unsigned B_OWN    = 29;
  localparam int unsigned B_EOQ    = 28;
  localparam int unsigned CMD_IDLE = 3;
  localparam int unsigned ST_IDLE  = 31;

  localparam int unsigned IX_HEAD = 0;
  localparam int unsigned IX_DONE = 1;
  localparam int unsigned IX_ENA  = 2;
  localparam int unsigned IX_CMD  = 3;
  localparam int unsigned IX_STAT = 4;
  localparam int unsigned IX_SRST = 5;

  typedef enum logic [3:0] {
    E_IDLE, E_LINK, E_BUFA, E_MODE, E_DATA, E_PUSH, E_DRAIN, E_WBACK, E_ADV
  } eng_st_t;
endpackage

// File: rtl/tdma_regs.sv
module tdma_regs
  import tdma_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned RIW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [RIW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           busy_i,
  input  logic           adv_i,
  input  logic [AW-1:0]  adv_ptr_i,
  input  logic           fault_i,
  output logic [AW-1:0]  head_o,
  output logic           run_o,
  output logic           srst_o
);
  localparam logic [RIW-1:0] A_HEAD = RIW'(IX_HEAD);
  localparam logic [RIW-1:0] A_DONE = RIW'(IX_DONE);
  localparam logic [RIW-1:0] A_ENA  = RIW'(IX_ENA);
  localparam logic [RIW-1:0] A_CMD  = RIW'(IX_CMD);
  localparam logic [RIW-1:0] A_STAT = RIW'(IX_STAT);
  localparam logic [RIW-1:0] A_SRST = RIW'(IX_SRST);

  logic [AW-1:0] head_q, done_q;
  logic          ena_q, idlereq_q, fault_q, srst_q;
  logic          head_wr, head_ok;

  assign head_wr = reg_we && (reg_addr == A_HEAD);
  assign head_ok = !busy_i && (head_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q    <= '0;
      done_q    <= '0;
      ena_q     <= 1'b0;
      idlereq_q <= 1'b0;
      fault_q   <= 1'b0;
      srst_q    <= 1'b0;
    end else if (srst_q) begin
      head_q    <= '0;
      done_q    <= '0;
      idlereq_q <= 1'b0;
      fault_q   <= 1'b0;
      srst_q    <= 1'b0;
    end else begin
      if (head_wr && head_ok)            head_q <= reg_wdata[AW-1:0];
      else if (adv_i)                    head_q <= adv_ptr_i;
      if (reg_we && reg_addr == A_DONE)  done_q <= reg_wdata[AW-1:0];
      if (reg_we && reg_addr == A_ENA)   ena_q <= reg_wdata[0];
      if (reg_we && reg_addr == A_CMD)   idlereq_q <= reg_wdata[CMD_IDLE];
      if (reg_we && reg_addr == A_SRST)  srst_q <= reg_wdata[0];
      if (fault_i)                       fault_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        A_HEAD:  reg_rdata <= 32'(head_q);
        A_DONE:  reg_rdata <= 32'(done_q);
        A_ENA:   reg_rdata <= {31'b0, ena_q};
        A_CMD:   reg_rdata <= 32'(idlereq_q) << CMD_IDLE;
        A_STAT:  reg_rdata <= (32'(!busy_i) << ST_IDLE) | {31'b0, fault_q};
        A_SRST:  reg_rdata <= {31'b0, srst_q};
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign head_o = head_q;
  assign run_o  = ena_q && !idlereq_q && !fault_q;
  assign srst_o = srst_q;

  AST_HEAD_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (head_wr && !head_ok && !adv_i && !srst_q) |=> (head_q == $past(head_q))); // R10
  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> (head_q == '0 && done_q == '0 && !fault_q && !srst_q)); // R12
endmodule

// File: rtl/tdma_engine.sv
module tdma_engine
  import tdma_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic [AW-1:0] head_i,
  output logic          busy_o,
  output logic          adv_o,
  output logic [AW-1:0] adv_ptr_o,
  output logic          fault_o,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata,
  output logic          ld_o,
  output logic [31:0]   ld_word_o,
  output logic [2:0]    ld_nb_o,
  output logic          ld_first_o,
  output logic          ld_last_o,
  input  logic          ser_busy_i
);
  localparam logic [AW-1:0] OFS_BUF  = AW'(4);
  localparam logic [AW-1:0] OFS_MODE = AW'(12);
  localparam logic [AW-1:0] STEP     = AW'(4);

  eng_st_t          st_q;
  logic [AW-1:0]    cur_q, link_q, addr_q;
  logic [AW-1:2]    bufa_q;
  logic [31:0]      mode_q, word_q;
  logic [LEN_W-1:0] left_q;
  logic             first_q;
  logic             last_chunk;
  logic [2:0]       chunk;

  assign last_chunk = left_q <= LEN_W'(4);
  assign chunk      = last_chunk ? left_q[2:0] : 3'd4;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= E_IDLE;
      cur_q   <= '0;
      link_q  <= '0;
      addr_q  <= '0;
      bufa_q  <= '0;
      mode_q  <= '0;
      word_q  <= '0;
      left_q  <= '0;
      first_q <= 1'b0;
    end else begin
      case (st_q)
        E_IDLE: if (run_i && head_i != '0) begin
          cur_q  <= head_i;
          addr_q <= head_i;
          st_q   <= E_LINK;
        end
        E_LINK: if (mem_ready) begin
          link_q <= mem_rdata[AW-1:0];
          addr_q <= cur_q + OFS_BUF;
          st_q   <= E_BUFA;
        end
        E_BUFA: if (mem_ready) begin
          bufa_q <= mem_rdata[AW-1:2];
          addr_q <= cur_q + OFS_MODE;
          st_q   <= E_MODE;
        end
        E_MODE: if (mem_ready) begin
          mode_q  <= mem_rdata;
          left_q  <= mem_rdata[LEN_W-1:0];
          first_q <= 1'b1;
          if (!mem_rdata[B_OWN])                     st_q <= E_IDLE;
          else if (mem_rdata[LEN_W-1:0] == '0)       st_q <= E_WBACK;
          else begin
            addr_q <= {bufa_q, 2'b00};
            st_q   <= E_DATA;
          end
        end
        E_DATA: if (mem_ready) begin
          word_q <= mem_rdata;
          st_q   <= E_PUSH;
        end
        E_PUSH: if (!ser_busy_i) begin
          left_q  <= left_q - LEN_W'(chunk);
          first_q <= 1'b0;
          if (last_chunk) begin
            addr_q <= cur_q + OFS_MODE;
            st_q   <= E_DRAIN;
          end else begin
            addr_q <= addr_q + STEP;
            st_q   <= E_DATA;
          end
        end
        E_DRAIN: if (!ser_busy_i) st_q <= E_WBACK;
        E_WBACK: if (mem_ready) st_q <= E_ADV;
        E_ADV:   st_q <= E_IDLE;
        default: st_q <= E_IDLE;
      endcase
    end
  end

  assign mem_req   = (st_q == E_LINK) || (st_q == E_BUFA) || (st_q == E_MODE) ||
                     (st_q == E_DATA) || (st_q == E_WBACK);
  assign mem_we    = (st_q == E_WBACK);
  assign mem_addr  = addr_q;
  assign mem_wdata = (mode_q & ~(32'd1 << B_OWN)) |
                     ((link_q == '0) ? (32'd1 << B_EOQ) : 32'd0);

  assign busy_o    = (st_q != E_IDLE);
  assign adv_o     = (st_q == E_ADV);
  assign adv_ptr_o = link_q;
  assign fault_o   = (st_q == E_MODE) && mem_ready && !mem_rdata[B_OWN];

  assign ld_o       = (st_q == E_PUSH) && !ser_busy_i;
  assign ld_word_o  = word_q;
  assign ld_nb_o    = chunk;
  assign ld_first_o = first_q;
  assign ld_last_o  = last_chunk;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R13
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (rst)
    fault_o |=> !mem_req); // R7
  AST_NO_START_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !run_i) |=> !mem_req); // R8
endmodule

// File: rtl/tdma_byte_out.sv
module tdma_byte_out (
  input  logic        clk,
  input  logic        rst,
  input  logic        ld_i,
  input  logic [31:0] word_i,
  input  logic [2:0]  nb_i,
  input  logic        first_i,
  input  logic        last_i,
  output logic        busy_o,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_sop,
  output logic        tx_eop
);
  logic [23:0] rest_q;
  logic [1:0]  left_q;
  logic        last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_sop   <= 1'b0;
      tx_eop   <= 1'b0;
      rest_q   <= '0;
      left_q   <= '0;
      last_q   <= 1'b0;
    end else if (ld_i) begin
      tx_valid <= 1'b1;
      tx_data  <= word_i[7:0];
      tx_sop   <= first_i;
      tx_eop   <= last_i && (nb_i == 3'd1);
      rest_q   <= word_i[31:8];
      left_q   <= 2'(nb_i - 3'd1);
      last_q   <= last_i;
    end else if (tx_valid && tx_ready) begin
      if (left_q != 2'd0) begin
        tx_data <= rest_q[7:0];
        rest_q  <= {8'h00, rest_q[23:8]};
        left_q  <= left_q - 2'd1;
        tx_sop  <= 1'b0;
        tx_eop  <= last_q && (left_q == 2'd1);
      end else begin
        tx_valid <= 1'b0;
        tx_sop   <= 1'b0;
        tx_eop   <= 1'b0;
      end
    end
  end

  assign busy_o = tx_valid;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop))); // R3
endmodule

// File: rtl/tdma_tx_chan.sv
module tdma_tx_chan
  import tdma_pkg::*;
#(
  parameter int unsigned AW  = 32,
  parameter int unsigned RIW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [RIW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic           mem_ready,
  input  logic [31:0]    mem_rdata,
  output logic           tx_valid,
  input  logic           tx_ready,
  output logic [7:0]     tx_data,
  output logic           tx_sop,
  output logic           tx_eop
);
  logic          busy, adv, fault, run, srst, eng_rst;
  logic [AW-1:0] adv_ptr, head;
  logic          ld, ld_first, ld_last, ser_busy;
  logic [31:0]   ld_word;
  logic [2:0]    ld_nb;

  assign eng_rst = rst || srst;

  tdma_regs #(.AW(AW), .RIW(RIW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_i(busy),
    .adv_i(adv), .adv_ptr_i(adv_ptr), .fault_i(fault), .head_o(head),
    .run_o(run), .srst_o(srst)
  );

  tdma_engine #(.AW(AW)) u_eng (
    .clk(clk), .rst(eng_rst), .run_i(run), .head_i(head), .busy_o(busy),
    .adv_o(adv), .adv_ptr_o(adv_ptr), .fault_o(fault),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .ld_o(ld), .ld_word_o(ld_word), .ld_nb_o(ld_nb), .ld_first_o(ld_first),
    .ld_last_o(ld_last), .ser_busy_i(ser_busy)
  );

  tdma_byte_out u_out (
    .clk(clk), .rst(eng_rst), .ld_i(ld), .word_i(ld_word), .nb_i(ld_nb),
    .first_i(ld_first), .last_i(ld_last), .busy_o(ser_busy),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop)
  );
endmodule

// File: tb/tb_tdma_tx_chan.sv
module tb_tdma_tx_chan;
  localparam int CLK_P = 10;
  localparam logic [2:0] X_HEAD = 3'd0, X_DONE = 3'd1, X_ENA = 3'd2,
                         X_CMD = 3'd3, X_STAT = 3'd4, X_SRST = 3'd5;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        tx_valid, tx_ready = 1'b0, tx_sop, tx_eop;
  logic [7:0]  tx_data;

  tdma_tx_chan dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop)
  );

  int checks = 0, errors = 0, cyc = 0, req_cycles = 0;
  bit bp = 1'b0;
  logic [15:0] lf = 16'hACE1;
  logic [31:0] mem [0:255];
  int          exp_b[$];
  logic [63:0] exp_w[$];
  logic [63:0] ew;
  int          eb;
  bit          pend = 1'b0;
  logic [31:0] pend_addr = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: expected bytes and write-backs, compared at each handshake
  always @(negedge clk) begin
    cyc++;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst) begin
      mem_ready = 1'b0;
      tx_ready  = 1'b0;
      pend      = 1'b0;
    end else begin
      if (pend) chk(mem_req && mem_addr == pend_addr, "R13 request held", {31'b0, mem_req, mem_addr}, {32'd1, pend_addr});
      mem_ready = mem_req && (lf[0] || lf[4]);
      mem_rdata = mem[mem_addr[9:2]];
      tx_ready  = bp ? lf[2] : 1'b1;
      pend      = mem_req && !mem_ready;
      pend_addr = mem_addr;
      if (mem_req) req_cycles++;
      if (mem_req && mem_ready && !mem_we && mem_addr < 32'h200)
        chk(mem_addr[3:2] != 2'b10, "R2 length word not read", mem_addr, 0);
      if (mem_req && mem_ready && mem_we) begin
        if (exp_w.size() == 0) chk(1'b0, "R4 unexpected write-back", {mem_addr, mem_wdata}, 0);
        else begin
          ew = exp_w.pop_front();
          chk({mem_addr, mem_wdata} == ew, "R4 write-back", {mem_addr, mem_wdata}, ew);
        end
        mem[mem_addr[9:2]] = mem_wdata;
      end
      if (tx_valid && tx_ready) begin
        if (exp_b.size() == 0) chk(1'b0, "R3 unexpected byte", {tx_sop, tx_eop, tx_data}, 0);
        else begin
          eb = exp_b.pop_front();
          chk({tx_sop, tx_eop, tx_data} == eb[9:0], "R3 stream byte", {tx_sop, tx_eop, tx_data}, eb);
        end
      end
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic put_desc(input int d, input int nxt, input int bufa, input int len,
                          input bit own, input int seed, input bit expect_it);
    logic [31:0] mode;
    mode = 32'hC000_0000 | (32'(own) << 29) | 32'(len);
    mem[d/4]     = nxt;
    mem[d/4 + 1] = bufa;
    mem[d/4 + 2] = 32'hFFFF_FFFF;
    mem[d/4 + 3] = mode;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'((seed + i * 7) & 255);
      mem[(bufa + i) / 4][8*((bufa + i) % 4) +: 8] = b;
      if (expect_it) exp_b.push_back(((i == 0) ? 512 : 0) | ((i == len - 1) ? 256 : 0) | int'(b));
    end
    if (expect_it)
      exp_w.push_back({32'(d + 12), (mode & ~32'h2000_0000) | ((nxt == 0) ? 32'h1000_0000 : 32'h0)});
  endtask

  task automatic drain(input string tag);
    int n;
    n = 0;
    while ((exp_b.size() != 0 || exp_w.size() != 0) && n < 20000) begin
      @(negedge clk); n++;
    end
    chk(n < 20000, tag, 64'(exp_b.size() + exp_w.size()), 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rv;
    int snap;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!mem_req && !tx_valid, "R1 outputs quiet", {mem_req, tx_valid}, 0);
    rd_reg(X_STAT, rv); chk(rv == 32'h8000_0000, "R1 status", rv, 32'h8000_0000);
    rd_reg(X_HEAD, rv); chk(rv == 0, "R1 head", rv, 0);
    rd_reg(X_DONE, rv); chk(rv == 0, "R1 completion", rv, 0);

    wr_reg(X_ENA, 1);
    // R2 R3 R4 single descriptor, partial last word
    put_desc(32'h40, 0, 32'h200, 5, 1, 17, 1);
    wr_reg(X_HEAD, 32'h40);
    drain("R3 single packet done");
    rd_reg(X_HEAD, rv); chk(rv == 0, "R5 head after end", rv, 0);
    rd_reg(X_STAT, rv); chk(rv == 32'h8000_0000, "R9 idle after packet", rv, 32'h8000_0000);

    // R11 completion pointer
    wr_reg(X_DONE, 32'h40);
    rd_reg(X_DONE, rv); chk(rv == 32'h40, "R11 completion readback", rv, 32'h40);

    // R5 chain of three with backpressure
    bp = 1'b1;
    put_desc(32'h50, 32'h60, 32'h240, 4, 1, 3, 1);
    put_desc(32'h60, 32'h70, 32'h260, 1, 1, 90, 1);
    put_desc(32'h70, 0, 32'h280, 9, 1, 200, 1);
    wr_reg(X_HEAD, 32'h50);
    drain("R5 chain done");
    bp = 1'b0;
    rd_reg(X_HEAD, rv); chk(rv == 0, "R5 head after chain", rv, 0);

    // R6 zero length
    put_desc(32'h80, 0, 32'h2A0, 0, 1, 0, 1);
    wr_reg(X_HEAD, 32'h80);
    drain("R6 zero length done");

    // R7 fault on owner clear
    put_desc(32'h90, 0, 32'h2C0, 3, 0, 5, 0);
    wr_reg(X_HEAD, 32'h90);
    repeat (20) @(negedge clk);
    snap = req_cycles;
    repeat (30) @(negedge clk);
    chk(req_cycles == snap, "R7 no further access", 64'(req_cycles), 64'(snap));
    rd_reg(X_STAT, rv); chk(rv == 32'h8000_0001, "R7 fault flag", rv, 32'h8000_0001);
    rd_reg(X_HEAD, rv); chk(rv == 32'h90, "R7 head kept", rv, 32'h90);

    // R12 soft reset
    wr_reg(X_CMD, 32'h8);
    wr_reg(X_SRST, 1);
    rd_reg(X_SRST, rv); chk(rv == 0, "R12 self-clear", rv, 0);
    rd_reg(X_HEAD, rv); chk(rv == 0, "R12 head cleared", rv, 0);
    rd_reg(X_DONE, rv); chk(rv == 0, "R12 completion cleared", rv, 0);
    rd_reg(X_STAT, rv); chk(rv == 32'h8000_0000, "R12 fault cleared", rv, 32'h8000_0000);
    rd_reg(X_CMD, rv); chk(rv == 0, "R12 idle command cleared", rv, 0);
    rd_reg(X_ENA, rv); chk(rv == 1, "R12 enable kept", rv, 1);

    // R8 disabled channel holds pending head
    wr_reg(X_ENA, 0);
    put_desc(32'hA0, 0, 32'h2E0, 6, 1, 33, 1);
    snap = req_cycles;
    wr_reg(X_HEAD, 32'hA0);
    repeat (40) @(negedge clk);
    chk(req_cycles == snap, "R8 no access while disabled", 64'(req_cycles), 64'(snap));
    rd_reg(X_HEAD, rv); chk(rv == 32'hA0, "R8 head pending", rv, 32'hA0);
    wr_reg(X_ENA, 1);
    drain("R8 resumes after enable");

    // R9 idle command
    wr_reg(X_CMD, 32'h8);
    put_desc(32'hB0, 0, 32'h300, 3, 1, 61, 1);
    snap = req_cycles;
    wr_reg(X_HEAD, 32'hB0);
    repeat (30) @(negedge clk);
    chk(req_cycles == snap, "R9 no start under idle command", 64'(req_cycles), 64'(snap));
    rd_reg(X_STAT, rv); chk(rv == 32'h8000_0000, "R9 status idle", rv, 32'h8000_0000);
    wr_reg(X_CMD, 0);
    drain("R9 resumes");

    // R10 and R14: head write while busy, late append
    put_desc(32'hC0, 0, 32'h340, 40, 1, 111, 1);
    wr_reg(X_HEAD, 32'hC0);
    snap = 0;
    while (exp_b.size() > 36 && snap < 5000) begin @(negedge clk); snap++; end
    mem[32'hC0/4] = 32'hD0;
    put_desc(32'hD0, 0, 32'h3C0, 2, 1, 77, 0);
    wr_reg(X_HEAD, 32'hD0);
    rd_reg(X_HEAD, rv); chk(rv == 32'hC0, "R10 busy head write ignored", rv, 32'hC0);
    drain("R14 first packet done");
    rd_reg(X_HEAD, rv); chk(rv == 0, "R14 late link not followed", rv, 0);
    chk(mem[32'hCC/4][28] == 1'b1, "R14 end-of-queue seen", 64'(mem[32'hCC/4]), 64'h1000_0000);
    put_desc(32'hD0, 0, 32'h3C0, 2, 1, 77, 1);
    wr_reg(X_HEAD, 32'hD0);
    drain("R14 restart sends appended");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule